// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, for each fetch slot of a cycle, which hardware thread of a multithreaded core is allowed to fetch. It looks at a 3-bit fetch state per thread, a mask of threads that are currently active, a 2-bit policy select and two per-thread occupancy counts: one for the issue queue and one for the load/store queue. For every slot it reports whether a thread was picked and which one. Up to `SLOTS` picks are made per cycle, and a thread picked by an earlier slot is not offered to a later slot in the same cycle.

Three selection schemes are offered. The fixed scheme always hands slot 0 to thread 0. The rotating scheme keeps an ordered list of thread indices. It takes the first usable thread from the head of that list and moves it to the tail. The occupancy scheme takes the usable thread whose selected queue count is smallest. The ordered list is the block's only state. It changes only when the rotating scheme actually grants a thread.

Top module: `fetch_thread_pick`

## Requirements
- R1: A thread is usable only when its state code is 0 (running), 1 (idle) or 2 (line returned from a miss). Codes 3 (blocked), 4 (flushing), 5 (waiting on a miss), 6 (trap pending) and 7 (sleep pending) make it unusable. This holds under policies 1, 2 and 3.
- R2: Under policies 1, 2 and 3, a thread whose bit in `thr_active_i` is 0 is never granted.
- R3: Under policies 1, 2 and 3, if no thread is both active and usable, every slot reports `pick_vld_o` bit 0.
- R4: Policy 0 (fixed), with more than one thread configured, grants thread 0 on slot 0 in every cycle, whatever that thread's state or active bit. All other slots report no grant.
- R5: Policy 1 (rotating) grants the first usable active thread found by walking the ordered list from its head. After reset the list is 0, 1, …, NUM_THREADS-1 from head to tail.
- R6: Each grant under policy 1 moves the granted thread to the tail of the list, and the threads behind it each move one place forward. Cycles spent under policies 0, 2 or 3 leave the list unchanged.
- R7: Policy 2 grants the usable active thread with the smallest `iq_cnt_i` field. Policy 3 does the same using `lsq_cnt_i`. When counts are equal, the lower thread index wins. Thread t's count occupies bits [t*CNT_W +: CNT_W].
- R8: Slot s considers only threads that slots 0..s-1 have not granted in the same cycle. Under policy 1, the list moves are applied in slot order, and the list left after the last slot is the one stored.
- R9: With NUM_THREADS = 1, under any policy, thread 0 is granted on slot 0 exactly when it is active and usable. No other slot ever grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_state_i | input | NUM_THREADS*3 | Fetch state code of thread t at bits [t*3 +: 3] |
| thr_active_i | input | NUM_THREADS | Active-thread mask |
| policy_i | input | 2 | 0 fixed, 1 rotating, 2 issue-queue count, 3 load/store-queue count |
| iq_cnt_i | input | NUM_THREADS*CNT_W | Issue-queue occupancy per thread |
| lsq_cnt_i | input | NUM_THREADS*CNT_W | Load/store-queue occupancy per thread |
| pick_vld_o | output | SLOTS | Grant valid per slot |
| pick_tid_o | output | SLOTS*TID_W | Granted thread of slot s at bits [s*TID_W +: TID_W] |

## Verification
The bench targets the following cases:
- A thread in the middle of the rotating list that is the only usable one. A rotation that shifted the wrong entries would then give the next cycle a wrong head.
- A return to the rotating policy after cycles under the occupancy policies. A design that rotated on every grant would resume from the wrong thread.
- Equal occupancy counts, where picking the higher index or comparing with less-or-equal would flip the grant.
- A second slot with only one usable thread, which a design without the per-cycle exclusion would grant twice.
- The fixed policy with thread 0 blocked, and a one-thread instance, where an eligibility filter that is wrongly applied or wrongly omitted would show up directly at the grant outputs.

// File: rtl/ftp_pkg.sv
// Shared encodings for the fetch thread selector.
// Assumes a 3-bit per-thread fetch state and a 2-bit policy select.
package ftp_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_LINE_READY = 3'd2,
        ST_BLOCKED    = 3'd3,
        ST_FLUSH      = 3'd4,
        ST_LINE_WAIT  = 3'd5,
        ST_TRAP_WAIT  = 3'd6,
        ST_SLEEP_WAIT = 3'd7
    } fstat_e;

    typedef enum logic [1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_IQ     = 2'd2,
        POL_LSQ    = 2'd3
    } fpol_e;

    // True for the states in which a thread may be handed a fetch slot
    function automatic logic can_fetch(input logic [2:0] code);
        return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_LINE_READY);
    endfunction

endpackage

// File: rtl/ftp_rr_slot.sv
// One rotating-list pick: walks the ordered list from its head, grants the
// first entry marked available, and returns the list with that entry moved
// to the tail. Assumes the list is a permutation of 0..NT-1.
module ftp_rr_slot #(
    parameter int NT = 4,
    parameter int TW = 2
) (
    input  logic [NT*TW-1:0] order_i,
    input  logic [NT-1:0]    avail_i,
    output logic             vld_o,
    output logic [TW-1:0]    tid_o,
    output logic [NT*TW-1:0] order_o
);

    // Find the head-most available entry and build the rotated list
    always_comb begin
        int          hit_pos;
        logic [TW-1:0] ent;
        vld_o   = 1'b0;
        tid_o   = '0;
        hit_pos = 0;
        for (int i = 0; i < NT; i++) begin
            ent = order_i[i*TW +: TW];
            for (int j = 0; j < NT; j++) begin
                if (!vld_o && (ent == TW'(j)) && avail_i[j]) begin
                    vld_o   = 1'b1;
                    tid_o   = ent;
                    hit_pos = i;
                end
            end
        end
        for (int i = 0; i < NT; i++) begin
            if (vld_o && (i >= hit_pos)) begin
                if (i == NT - 1)
                    order_o[i*TW +: TW] = tid_o;
                else
                    order_o[i*TW +: TW] = order_i[((i + 1) % NT)*TW +: TW];
            end else begin
                order_o[i*TW +: TW] = order_i[i*TW +: TW];
            end
        end
    end

endmodule

// File: rtl/ftp_occ_slot.sv
// One occupancy pick: grants the available thread with the smallest count,
// the lower index winning a tie. Assumes counts are unsigned.
module ftp_occ_slot #(
    parameter int NT = 4,
    parameter int TW = 2,
    parameter int CW = 5
) (
    input  logic [NT*CW-1:0] cnt_i,
    input  logic [NT-1:0]    avail_i,
    output logic             vld_o,
    output logic [TW-1:0]    tid_o
);

    // Ascending scan keeping the strictly smaller count
    always_comb begin
        logic [CW-1:0] best;
        vld_o = 1'b0;
        tid_o = '0;
        best  = '0;
        for (int i = 0; i < NT; i++) begin
            if (avail_i[i] && (!vld_o || (cnt_i[i*CW +: CW] < best))) begin
                vld_o = 1'b1;
                best  = cnt_i[i*CW +: CW];
                tid_o = TW'(i);
            end
        end
    end

endmodule

// File: rtl/fetch_thread_pick.sv
// Fetch thread selector. Each cycle fills up to SLOTS fetch slots with
// distinct threads under the policy on policy_i. Only state: the rotating
// priority list, reset to ascending order. Outputs are combinational from
// the inputs and that list.
module fetch_thread_pick #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 5,
    parameter int SLOTS       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS*3-1:0]     thr_state_i,
    input  logic [NUM_THREADS-1:0]       thr_active_i,
    input  logic [1:0]                   policy_i,
    input  logic [NUM_THREADS*CNT_W-1:0] iq_cnt_i,
    input  logic [NUM_THREADS*CNT_W-1:0] lsq_cnt_i,
    output logic [SLOTS-1:0]             pick_vld_o,
    output logic [SLOTS*((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] pick_tid_o
);
    import ftp_pkg::*;

    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
    localparam int ORD_W = NUM_THREADS * TID_W;
    localparam bit MULTI = (NUM_THREADS > 1);

    logic [NUM_THREADS-1:0]       usable;
    logic [NUM_THREADS*CNT_W-1:0] occ_cnt;
    logic                         fixed_mode;
    logic                         rotate_mode;
    logic [ORD_W-1:0]             order_q;

    logic [SLOTS:0][NUM_THREADS-1:0] taken;
    logic [SLOTS:0][ORD_W-1:0]       order_chain;
    logic [SLOTS-1:0][NUM_THREADS-1:0] grant_mask;
    logic [SLOTS-1:0]                slot_vld;
    logic [SLOTS-1:0][TID_W-1:0]     slot_tid;

    // Per-thread usability: active and in a fetchable state
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_use
        assign usable[t] = thr_active_i[t] && can_fetch(thr_state_i[t*3 +: 3]);
    end

    // Policy decode and count source selection
    assign fixed_mode  = MULTI && (policy_i == POL_FIXED);
    assign rotate_mode = (policy_i == POL_ROTATE);
    assign occ_cnt     = (policy_i == POL_LSQ) ? lsq_cnt_i : iq_cnt_i;

    assign taken[0]       = '0;
    assign order_chain[0] = order_q;

    // Chain of slot stages, each excluding threads granted before it
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [NUM_THREADS-1:0] avail;
        logic                   rr_vld;
        logic [TID_W-1:0]       rr_tid;
        logic [ORD_W-1:0]       rr_order;
        logic                   occ_vld;
        logic [TID_W-1:0]       occ_tid;

        assign avail = usable & ~taken[s];

        ftp_rr_slot #(.NT(NUM_THREADS), .TW(TID_W)) u_rr (
            .order_i (order_chain[s]),
            .avail_i (avail),
            .vld_o   (rr_vld),
            .tid_o   (rr_tid),
            .order_o (rr_order)
        );

        ftp_occ_slot #(.NT(NUM_THREADS), .TW(TID_W), .CW(CNT_W)) u_occ (
            .cnt_i   (occ_cnt),
            .avail_i (avail),
            .vld_o   (occ_vld),
            .tid_o   (occ_tid)
        );

        assign slot_vld[s] = fixed_mode  ? 1'(s == 0) :
                             rotate_mode ? rr_vld : occ_vld;
        assign slot_tid[s] = fixed_mode  ? '0 :
                             rotate_mode ? rr_tid : occ_tid;

        assign grant_mask[s]      = slot_vld[s] ? (NUM_THREADS'(1) << slot_tid[s]) : '0;
        assign taken[s+1]         = taken[s] | grant_mask[s];
        assign order_chain[s+1]   = rotate_mode ? rr_order : order_chain[s];
        assign pick_vld_o[s]      = slot_vld[s];
        assign pick_tid_o[s*TID_W +: TID_W] = slot_tid[s];
    end

    // Priority list register: ascending after reset, rotated by grants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++)
                order_q[i*TID_W +: TID_W] <= TID_W'(i);
        end else begin
            order_q <= order_chain[SLOTS];
        end
    end

endmodule

// File: rtl/ftp_checker.sv
// Property checker for fetch_thread_pick, attached by bind below.
// Assumes the parameters match the bound instance.
module ftp_checker #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 5,
    parameter int SLOTS       = 2,
    parameter int TID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_THREADS*3-1:0]     thr_state_i,
    input logic [NUM_THREADS-1:0]       thr_active_i,
    input logic [1:0]                   policy_i,
    input logic [NUM_THREADS*CNT_W-1:0] iq_cnt_i,
    input logic [NUM_THREADS*CNT_W-1:0] lsq_cnt_i,
    input logic [SLOTS-1:0]             pick_vld_o,
    input logic [SLOTS*TID_W-1:0]       pick_tid_o,
    input logic [NUM_THREADS*TID_W-1:0] order_q
);
    localparam bit MULTI = (NUM_THREADS > 1);

    logic                   fixed_sel;
    logic [NUM_THREADS-1:0] ok_mask;
    logic [TID_W-1:0]       last_tid;
    logic                   min_ok;

    // Reference view of which threads may fetch
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++)
            ok_mask[t] = thr_active_i[t] && (thr_state_i[t*3 +: 3] <= 3'd2);
    end

    assign fixed_sel = MULTI && (policy_i == 2'd0);

    // Thread granted by the highest valid slot
    always_comb begin
        last_tid = '0;
        for (int s = 0; s < SLOTS; s++)
            if (pick_vld_o[s]) last_tid = pick_tid_o[s*TID_W +: TID_W];
    end

    // Slot-0 occupancy grant must not be beaten by any usable thread
    always_comb begin
        logic [CNT_W-1:0] c_g;
        logic [CNT_W-1:0] c_i;
        min_ok = 1'b1;
        c_g    = '0;
        for (int t = 0; t < NUM_THREADS; t++)
            if (pick_tid_o[TID_W-1:0] == TID_W'(t))
                c_g = (policy_i == 2'd3) ? lsq_cnt_i[t*CNT_W +: CNT_W] : iq_cnt_i[t*CNT_W +: CNT_W];
        for (int t = 0; t < NUM_THREADS; t++) begin
            c_i = (policy_i == 2'd3) ? lsq_cnt_i[t*CNT_W +: CNT_W] : iq_cnt_i[t*CNT_W +: CNT_W];
            if (ok_mask[t] && ((c_i < c_g) || ((c_i == c_g) && (TID_W'(t) < pick_tid_o[TID_W-1:0]))))
                min_ok = 1'b0;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_sa
        logic [TID_W-1:0] tid_s;
        assign tid_s = pick_tid_o[s*TID_W +: TID_W];

        // R1 and R2: outside fixed mode only usable active threads are granted
        assert_usable_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_vld_o[s] && !fixed_sel) |-> ok_mask[tid_s]);
        assert_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_vld_o[s] && !fixed_sel) |-> thr_active_i[tid_s]);

        for (genvar r = s + 1; r < SLOTS; r++) begin : g_pair
            // R8: slots in one cycle never share a thread
            assert_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (pick_vld_o[s] && pick_vld_o[r]) |-> (tid_s != pick_tid_o[r*TID_W +: TID_W]));
        end
    end

    // R3: nothing usable means no grant anywhere
    assert_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fixed_sel && (ok_mask == '0)) |-> (pick_vld_o == '0));

    // R4: fixed mode hands slot 0 to thread 0 and nothing else
    assert_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_sel |-> ((pick_vld_o == SLOTS'(1)) && (pick_tid_o[TID_W-1:0] == '0)));

    // R6: a rotating grant lands the last granted thread at the tail
    assert_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((policy_i == 2'd1) && (pick_vld_o != '0)) |=>
            (order_q[(NUM_THREADS-1)*TID_W +: TID_W] == $past(last_tid)));

    // R6: non-rotating policies leave the list alone
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i != 2'd1) |=> $stable(order_q));

    // R7: occupancy grant is the minimum with lower-index tie break
    assert_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i[1] && pick_vld_o[0]) |-> min_ok);

endmodule

bind fetch_thread_pick ftp_checker #(
    .NUM_THREADS (NUM_THREADS),
    .CNT_W       (CNT_W),
    .SLOTS       (SLOTS),
    .TID_W       (TID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_state_i  (thr_state_i),
    .thr_active_i (thr_active_i),
    .policy_i     (policy_i),
    .iq_cnt_i     (iq_cnt_i),
    .lsq_cnt_i    (lsq_cnt_i),
    .pick_vld_o   (pick_vld_o),
    .pick_tid_o   (pick_tid_o),
    .order_q      (order_q)
);

// File: tb/sim_fetch_thread_pick.sv
// Bench: behavioural reference model (queue-based priority list) compared
// with the design after every input change; a one-thread instance rides along.
module sim_fetch_thread_pick;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int CW = 5;
    localparam int SL = 2;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT*3-1:0]  st;
    logic [NT-1:0]    act;
    logic [1:0]       pol;
    logic [NT*CW-1:0] iq;
    logic [NT*CW-1:0] lsq;
    logic [SL-1:0]    vld;
    logic [SL*TW-1:0] tid;

    logic [2:0]    st1;
    logic          act1;
    logic [CW-1:0] iq1;
    logic [CW-1:0] lsq1;
    logic [SL-1:0] vld1;
    logic [SL-1:0] tid1;

    int errors = 0;
    int checks = 0;
    int plist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_thread_pick #(.NUM_THREADS(NT), .CNT_W(CW), .SLOTS(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_state_i(st), .thr_active_i(act),
        .policy_i(pol), .iq_cnt_i(iq), .lsq_cnt_i(lsq),
        .pick_vld_o(vld), .pick_tid_o(tid));

    fetch_thread_pick #(.NUM_THREADS(1), .CNT_W(CW), .SLOTS(SL)) u1 (
        .clk(clk), .rst_n(rst_n), .thr_state_i(st1), .thr_active_i(act1),
        .policy_i(pol), .iq_cnt_i(iq1), .lsq_cnt_i(lsq1),
        .pick_vld_o(vld1), .pick_tid_o(tid1));

    function automatic int cnt_of(int t);
        return (pol == 2'd3) ? int'(lsq[t*CW +: CW]) : int'(iq[t*CW +: CW]);
    endfunction

    // Compare design against the model for the current inputs, then clock
    task automatic step(input string tag);
        bit ev[SL];
        int et[SL];
        bit taken[NT];
        int q[$];
        bit ev1;
        #1;
        q = plist;
        foreach (taken[i]) taken[i] = 0;
        for (int s = 0; s < SL; s++) begin
            ev[s] = 0; et[s] = 0;
            if (pol == 2'd0) begin
                ev[s] = (s == 0);
            end else if (pol == 2'd1) begin
                for (int k = 0; k < NT; k++) begin
                    int t = q[k];
                    if (!ev[s] && act[t] && st[t*3 +: 3] <= 3 && st[t*3 +: 3] != 3 && !taken[t]) begin
                        ev[s] = 1; et[s] = t;
                        q.delete(k); q.push_back(t);
                        break;
                    end
                end
            end else begin
                for (int t = 0; t < NT; t++)
                    if (act[t] && st[t*3 +: 3] <= 2 && !taken[t] && (!ev[s] || cnt_of(t) < cnt_of(et[s]))) begin
                        ev[s] = 1; et[s] = t;
                    end
            end
            if (ev[s]) taken[et[s]] = 1;
        end
        for (int s = 0; s < SL; s++) begin
            checks++;
            if (vld[s] !== ev[s] || (ev[s] && int'(tid[s*TW +: TW]) != et[s])) begin
                errors++;
                $display("FAIL %s slot%0d: got vld=%0d tid=%0d, expected vld=%0d tid=%0d",
                         tag, s, vld[s], tid[s*TW +: TW], ev[s], et[s]);
            end
        end
        // R9: single-thread instance
        ev1 = act1 && (st1 <= 3'd2);
        checks++;
        if (vld1 !== {1'b0, ev1} || (ev1 && tid1[0] !== 1'b0)) begin
            errors++;
            $display("FAIL R9 one-thread: got vld=%b tid=%b, expected vld=%b tid=00",
                     vld1, tid1, {1'b0, ev1});
        end
        if (pol == 2'd1) plist = q;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_all(input logic [2:0] code);
        for (int t = 0; t < NT; t++) st[t*3 +: 3] = code;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        st = '0; act = '1; pol = 2'd1; iq = '0; lsq = '0;
        st1 = 3'd0; act1 = 1'b1; iq1 = '0; lsq1 = '0;
        plist = {0, 1, 2, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset order and head-first walk
        step("R5 reset order");
        step("R5 rotation");
        step("R5 wrap");

        // R1: each state code on thread 2 alone
        act = 4'b0100; pol = 2'd2;
        for (int c = 0; c < 8; c++) begin
            st[2*3 +: 3] = 3'(c); st1 = 3'(c);
            step("R1 state code");
        end

        // R2: inactive threads skipped
        set_all(3'd0); act = 4'b0101; pol = 2'd1;
        step("R2 inactive rr");
        pol = 2'd3; act = 4'b1010;
        step("R2 inactive occ");

        // R3: nothing usable
        set_all(3'd5); act = '1;
        for (int p = 1; p < 4; p++) begin
            pol = 2'(p);
            step("R3 none usable");
        end

        // R4: fixed policy even with thread 0 blocked and inactive
        pol = 2'd0; act = 4'b1110; st[2:0] = 3'd3;
        step("R4 fixed");

        // R7: minimum count with tie to lower index
        set_all(3'd0); act = '1; pol = 2'd2;
        iq = {5'd9, 5'd3, 5'd3, 5'd5};
        step("R7 iq tie");
        pol = 2'd3; lsq = {5'd1, 5'd7, 5'd1, 5'd2};
        step("R7 lsq tie");

        // R6: middle thread granted, list held under other policies
        pol = 2'd1; act = 4'b0100;
        step("R6 middle grant");
        act = '1;
        step("R6 after move");
        pol = 2'd2; step("R6 hold iq");
        pol = 2'd0; step("R6 hold fixed");
        pol = 2'd1; step("R6 resume");

        // R8: second slot with a single usable thread
        act = 4'b1000;
        step("R8 one usable");
        act = '1; st = {3'd0, 3'd4, 3'd0, 3'd6};
        step("R8 two usable");

        // R9: one-thread instance under each policy and state
        for (int p = 0; p < 4; p++) begin
            pol = 2'(p);
            st1 = 3'(p * 2); act1 = p[0];
            step("R9 one thread");
        end
        act1 = 1'b1;

        // Random mixed traffic
        for (int n = 0; n < 1500; n++) begin
            pol  = 2'($urandom_range(0, 3));
            act  = NT'($urandom);
            for (int t = 0; t < NT; t++) begin
                st[t*3 +: 3]   = ($urandom_range(0, 1) == 1) ? 3'($urandom_range(0, 2)) : 3'($urandom);
                iq[t*CW +: CW]  = CW'($urandom_range(0, 7));
                lsq[t*CW +: CW] = CW'($urandom_range(0, 7));
            end
            st1  = 3'($urandom);
            act1 = 1'($urandom);
            case (pol)
                2'd0:    step("R4 random");
                2'd1:    step("R8 random rr");
                default: step("R7 random occ");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule